// File: doc/BRIEF.md
# Processor status word bank

This block keeps the live status word of a processor core together with five saved status words, one for each privileged operating mode. The live word carries the four condition flags, two interrupt-disable bits and a five-bit mode field; the saved words hold a snapshot of the live word taken when an exception is entered. The surrounding core uses the block in three ways: it writes a status word, it reads a status word, and it triggers exception entry.

Reads and writes select either the live word or "the saved word". The saved word meant is never named explicitly: it is the one belonging to the mode the core is in now. The 26-bit and 32-bit variants of a mode share one saved word. Exception entry copies the live word into the saved word of the mode being entered. It then switches to that mode and masks interrupts. A write that would put an unsupported code into a mode field keeps the old mode and still takes the other fields. While the core runs in user mode, the interrupt masks and the mode cannot be changed by a write, and the saved words cannot be reached.

Top module: `psr_bank`

## Requirements
- R1: After reset the live word reads 0x000000D3: mode 10011, both interrupt-disable bits set, flags clear. Every saved word reads zero.
- R2: Word layout: flags N,Z,C,V occupy bits 31..28, the normal-interrupt disable is bit 7, the fast-interrupt disable is bit 6, and the mode is bits 4..0. All other bits always read zero. The `flags`, `irq_mask`, `fiq_mask` and `cur_mode` outputs equal those fields of the live word.
- R3: Only the mode codes 00000, 00001, 00010, 00011, 10000, 10001, 10010, 10011, 10111 and 11011 are legal; 00111, 01011 and every other code are illegal. A write to a live or saved word whose mode field is illegal leaves that word's mode unchanged and still updates its flags and interrupt bits.
- R4: In a privileged mode (any legal mode other than 00000 and 10000), a write to the live word replaces its flags, both interrupt bits and (subject to R3) its mode.
- R5: In user mode (00000 or 10000), a write to the live word changes only bits 31..28. Mode and interrupt bits keep their values.
- R6: A saved-word access uses the current mode to pick the bank. 00001/10001 select the fast-interrupt bank, 00010/10010 the interrupt bank, and 00011/10011 the supervisor bank. 10111 selects the abort bank and 11011 the undefined bank. Writing one bank leaves the other four unchanged.
- R7: In user mode, a saved-word read returns zero and a saved-word write changes no saved word.
- R8: Exception entry to a privileged target mode copies the live word into the target's saved word. The live mode becomes the target and bit 7 is set. Bit 6 is also set when the target is 00001 or 10001, and is kept otherwise. The flags are kept.
- R9: An exception request whose target is a user mode or an illegal code changes nothing.
- R10: When an exception entry and a write occur in the same cycle, the entry takes effect and the write is dropped.
- R11: `rd_data` follows `rd_sel_saved` combinationally. Writes and exception entries become visible only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write request |
| wr_sel_saved | input | 1 | Write target: 0 live word, 1 saved word of current mode |
| wr_data | input | 32 | Word to write |
| rd_sel_saved | input | 1 | Read source: 0 live word, 1 saved word of current mode |
| rd_data | output | 32 | Selected word |
| exc_en | input | 1 | Exception entry request |
| exc_mode | input | 5 | Mode entered on exception |
| cur_mode | output | 5 | Live mode field |
| flags | output | 4 | Live N,Z,C,V flags |
| irq_mask | output | 1 | Normal interrupts disabled |
| fiq_mask | output | 1 | Fast interrupts disabled |

## Verification
The bench uses the default build: a 32-bit word with five saved banks and a supervisor reset mode. At that size every one of the 32 mode codes can be swept, both as a write to the live word and as an exception target. That sweep proves the ten-code legality set and the rejection of 00111 and 01011. It also visits each 26-bit and 32-bit alias and checks that a saved word is shared by both variants of a mode. A long pseudo-random run of mixed writes, reads and exception requests is checked against an arithmetic model of all six words, and it keeps moving into and out of user mode.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int PSR_W     = 32;
  localparam int MODE_W    = 5;
  localparam int NUM_SAVED = 5;
  localparam int FLAG_HI   = PSR_W - 1;
  localparam int FLAG_LO   = PSR_W - 4;
  localparam int IRQ_BIT   = 7;
  localparam int FIQ_BIT   = 6;

  localparam logic [PSR_W-1:0] IMPL_MASK = 32'hF000_00DF;

  localparam int BANK_FIQ = 0;
  localparam int BANK_IRQ = 1;
  localparam int BANK_SVC = 2;
  localparam int BANK_ABT = 3;
  localparam int BANK_UND = 4;

  localparam logic [MODE_W-1:0] M_USR26 = 5'b00000;
  localparam logic [MODE_W-1:0] M_FIQ26 = 5'b00001;
  localparam logic [MODE_W-1:0] M_IRQ26 = 5'b00010;
  localparam logic [MODE_W-1:0] M_SVC26 = 5'b00011;
  localparam logic [MODE_W-1:0] M_USR32 = 5'b10000;
  localparam logic [MODE_W-1:0] M_FIQ32 = 5'b10001;
  localparam logic [MODE_W-1:0] M_IRQ32 = 5'b10010;
  localparam logic [MODE_W-1:0] M_SVC32 = 5'b10011;
  localparam logic [MODE_W-1:0] M_ABT32 = 5'b10111;
  localparam logic [MODE_W-1:0] M_UND32 = 5'b11011;

  // Combine an incoming word with the word it replaces.
  function automatic logic [PSR_W-1:0] psr_merge(
    input logic [PSR_W-1:0] old_w,
    input logic [PSR_W-1:0] new_w,
    input logic             flags_only,
    input logic             mode_ok
  );
    logic [PSR_W-1:0] r;
    if (flags_only) begin
      r = old_w;
      r[FLAG_HI:FLAG_LO] = new_w[FLAG_HI:FLAG_LO];
    end else begin
      r = new_w;
      if (!mode_ok) r[MODE_W-1:0] = old_w[MODE_W-1:0];
    end
    return r & IMPL_MASK;
  endfunction
endpackage

// File: rtl/psr_rst_sync.sv
module psr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/psr_mode_check.sv
module psr_mode_check
  import psr_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output logic              legal
);
  always_comb begin
    unique case (mode)
      M_USR26, M_FIQ26, M_IRQ26, M_SVC26,
      M_USR32, M_FIQ32, M_IRQ32, M_SVC32,
      M_ABT32, M_UND32: legal = 1'b1;
      default:          legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/psr_bank_decode.sv
module psr_bank_decode
  import psr_pkg::*;
(
  input  logic [MODE_W-1:0]    mode,
  output logic [NUM_SAVED-1:0] bank_oh
);
  always_comb begin
    bank_oh = '0;
    unique case (mode)
      M_FIQ26, M_FIQ32: bank_oh[BANK_FIQ] = 1'b1;
      M_IRQ26, M_IRQ32: bank_oh[BANK_IRQ] = 1'b1;
      M_SVC26, M_SVC32: bank_oh[BANK_SVC] = 1'b1;
      M_ABT32:          bank_oh[BANK_ABT] = 1'b1;
      M_UND32:          bank_oh[BANK_UND] = 1'b1;
      default:          bank_oh = '0;
    endcase
  end
endmodule

// File: rtl/psr_saved_bank.sv
module psr_saved_bank
  import psr_pkg::*;
#(
  parameter int WORD_W  = PSR_W,
  parameter int ENTRIES = NUM_SAVED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ENTRIES-1:0] we,
  input  logic [WORD_W-1:0]  wdata,
  output logic [WORD_W-1:0]  words [ENTRIES]
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] word_d;

    always_comb begin
      word_d = word_q;
      if (we[g]) word_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     word_q <= '0;
      else if (we[g]) word_q <= word_d;
    end

    assign words[g] = word_q;
  end

  AST_ONE_BANK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we)); // R6
endmodule

// File: rtl/psr_bank.sv
module psr_bank
  import psr_pkg::*;
#(
  parameter logic [MODE_W-1:0] RESET_MODE = M_SVC32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel_saved,
  input  logic [PSR_W-1:0]  wr_data,
  input  logic              rd_sel_saved,
  output logic [PSR_W-1:0]  rd_data,
  input  logic              exc_en,
  input  logic [MODE_W-1:0] exc_mode,
  output logic [MODE_W-1:0] cur_mode,
  output logic [3:0]        flags,
  output logic              irq_mask,
  output logic              fiq_mask
);
  localparam logic [PSR_W-1:0] RESET_WORD =
    (PSR_W'(1) << IRQ_BIT) | (PSR_W'(1) << FIQ_BIT) | PSR_W'(RESET_MODE);

  logic                 rst_n_s;
  logic [PSR_W-1:0]     cur_q;
  logic [PSR_W-1:0]     cur_d;
  logic                 cur_en;
  logic [NUM_SAVED-1:0] cur_bank_oh;
  logic [NUM_SAVED-1:0] tgt_bank_oh;
  logic                 cur_mode_ok;
  logic                 wr_mode_ok;
  logic                 cur_priv;
  logic                 exc_go;
  logic [PSR_W-1:0]     saved_words [NUM_SAVED];
  logic [PSR_W-1:0]     saved_sel;
  logic [NUM_SAVED-1:0] bank_we;
  logic [PSR_W-1:0]     bank_wdata;
  logic                 wr_cur;
  logic                 wr_sav;

  psr_rst_sync i_rst_sync (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  psr_mode_check  i_cur_chk (.mode(cur_q[MODE_W-1:0]),   .legal(cur_mode_ok));
  psr_mode_check  i_wr_chk  (.mode(wr_data[MODE_W-1:0]), .legal(wr_mode_ok));
  psr_bank_decode i_cur_dec (.mode(cur_q[MODE_W-1:0]),   .bank_oh(cur_bank_oh));
  psr_bank_decode i_tgt_dec (.mode(exc_mode),            .bank_oh(tgt_bank_oh));

  assign cur_priv = |cur_bank_oh;
  assign exc_go   = exc_en & (|tgt_bank_oh);
  assign wr_cur   = wr_en & ~wr_sel_saved & ~exc_go;
  assign wr_sav   = wr_en &  wr_sel_saved & ~exc_go;

  // Saved word of the current mode; zero in user mode.
  always_comb begin
    saved_sel = '0;
    for (int i = 0; i < NUM_SAVED; i++) begin
      if (cur_bank_oh[i]) saved_sel = saved_sel | saved_words[i];
    end
  end

  // Live word next state.
  always_comb begin
    cur_d  = cur_q;
    cur_en = 1'b0;
    if (exc_go) begin
      cur_en               = 1'b1;
      cur_d[MODE_W-1:0]    = exc_mode;
      cur_d[IRQ_BIT]       = 1'b1;
      if (tgt_bank_oh[BANK_FIQ]) cur_d[FIQ_BIT] = 1'b1;
      cur_d                = cur_d & IMPL_MASK;
    end else if (wr_cur) begin
      cur_en = 1'b1;
      cur_d  = psr_merge(cur_q, wr_data, ~cur_priv, wr_mode_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    cur_q <= RESET_WORD;
    else if (cur_en) cur_q <= cur_d;
  end

  // Saved bank write steering.
  always_comb begin
    bank_we    = '0;
    bank_wdata = psr_merge(saved_sel, wr_data, 1'b0, wr_mode_ok);
    if (exc_go) begin
      bank_we    = tgt_bank_oh;
      bank_wdata = cur_q;
    end else if (wr_sav) begin
      bank_we    = cur_bank_oh;
    end
  end

  psr_saved_bank #(.WORD_W(PSR_W), .ENTRIES(NUM_SAVED)) i_saved (
    .clk   (clk),
    .rst_n (rst_n_s),
    .we    (bank_we),
    .wdata (bank_wdata),
    .words (saved_words)
  );

  assign rd_data  = rd_sel_saved ? saved_sel : cur_q;
  assign cur_mode = cur_q[MODE_W-1:0];
  assign flags    = cur_q[FLAG_HI:FLAG_LO];
  assign irq_mask = cur_q[IRQ_BIT];
  assign fiq_mask = cur_q[FIQ_BIT];

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n_s)
    cur_mode_ok); // R3

  AST_WRITE_TAKES_FLAGS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && !wr_sel_saved && !exc_en) |=> (flags == $past(wr_data[FLAG_HI:FLAG_LO]))); // R4

  AST_USER_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!cur_priv && !exc_go) |=> (cur_q[7:0] == $past(cur_q[7:0]))); // R5

  AST_USER_SAVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cur_mode[3:0] == 4'b0000 && rd_sel_saved) |-> (rd_data == '0)); // R7

  AST_EXC_MASKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n_s)
    exc_go |=> (irq_mask && cur_mode == $past(exc_mode))); // R8

  AST_EXC_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n_s)
    exc_go |=> (saved_sel == $past(cur_q))); // R8

  AST_BAD_EXC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n_s)
    (exc_en && !exc_go && !wr_en) |=> $stable(cur_q)); // R9

  AST_EXC_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (exc_go && wr_en) |=> (flags == $past(flags))); // R10
endmodule

// File: tb/test_psr_bank.sv
module test_psr_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic        wr_sel_saved;
  logic [31:0] wr_data;
  logic        rd_sel_saved;
  logic [31:0] rd_data;
  logic        exc_en;
  logic [4:0]  exc_mode;
  logic [4:0]  cur_mode;
  logic [3:0]  flags;
  logic        irq_mask;
  logic        fiq_mask;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 1'b0;

  logic [31:0] m_cur;
  logic [31:0] m_sav [5];
  logic [31:0] lfsr = 32'h1D2C_3B4A;

  always #10 clk = ~clk;

  psr_bank i_psr_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel_saved(wr_sel_saved),
    .wr_data(wr_data), .rd_sel_saved(rd_sel_saved), .rd_data(rd_data),
    .exc_en(exc_en), .exc_mode(exc_mode), .cur_mode(cur_mode), .flags(flags),
    .irq_mask(irq_mask), .fiq_mask(fiq_mask)
  );

  function automatic bit legal(input logic [4:0] m);
    case (m)
      5'b00000, 5'b00001, 5'b00010, 5'b00011, 5'b10000,
      5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int bank_of(input logic [4:0] m);
    case (m)
      5'b00001, 5'b10001: return 0;
      5'b00010, 5'b10010: return 1;
      5'b00011, 5'b10011: return 2;
      5'b10111:           return 3;
      5'b11011:           return 4;
      default:            return -1;
    endcase
  endfunction

  function automatic logic [31:0] model_write(input logic [31:0] old_w,
                                              input logic [31:0] d,
                                              input bit user);
    logic [31:0] r;
    if (user) r = {d[31:28], old_w[27:0]};
    else begin
      r = {d[31:28], 20'h0, d[7:6], 1'b0, d[4:0]};
      if (!legal(d[4:0])) r[4:0] = old_w[4:0];
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    int b;
    b = bank_of(m_cur[4:0]);
    rd_sel_saved = 1'b0;
    #1;
    chk(tag, rd_data, m_cur);
    chk("R2 fields", {flags, 20'h0, irq_mask, fiq_mask, 1'b0, cur_mode},
        {m_cur[31:28], 20'h0, m_cur[7], m_cur[6], 1'b0, m_cur[4:0]});
    rd_sel_saved = 1'b1;
    #1;
    if (b < 0) chk("R7 user saved read", rd_data, 32'h0);
    else       chk({tag, " R6 saved"}, rd_data, m_sav[b]);
    rd_sel_saved = 1'b0;
  endtask

  task automatic apply(input bit we, input bit ws, input logic [31:0] d,
                       input bit ex, input logic [4:0] em, input string tag);
    int cb;
    int tb;
    @(negedge clk);
    wr_en = we; wr_sel_saved = ws; wr_data = d; exc_en = ex; exc_mode = em;
    rd_sel_saved = 1'b0;
    #1;
    chk("R11 pre-edge", rd_data, m_cur);
    @(posedge clk);
    #2;
    cb = bank_of(m_cur[4:0]);
    tb = bank_of(em);
    if (ex && tb >= 0) begin
      m_sav[tb] = m_cur;
      m_cur[4:0] = em;
      m_cur[7] = 1'b1;
      if (tb == 0) m_cur[6] = 1'b1;
    end else if (we && !ws) begin
      m_cur = model_write(m_cur, d, cb < 0);
    end else if (we && ws && cb >= 0) begin
      m_sav[cb] = model_write(m_sav[cb], d, 1'b0);
    end
    wr_en = 1'b0; exc_en = 1'b0;
    check_all(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [4:0] codes [8];
    codes = '{5'b00001, 5'b00010, 5'b00011, 5'b10001,
              5'b10010, 5'b10011, 5'b10111, 5'b11011};
    rst_n = 1'b0; wr_en = 1'b0; wr_sel_saved = 1'b0; wr_data = '0;
    rd_sel_saved = 1'b0; exc_en = 1'b0; exc_mode = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    // R1: reset state
    m_cur = 32'h0000_00D3;
    for (int i = 0; i < 5; i++) m_sav[i] = 32'h0;
    check_all("R1 reset");

    // R3/R4: every mode code written to the live word from supervisor
    for (int m = 0; m < 32; m++) begin
      apply(1'b0, 1'b0, 32'h0, 1'b1, 5'b10011, "R8 enter svc");
      apply(1'b1, 1'b0, {4'(m), 20'hABCDE, 2'(m), 1'b1, 5'(m)}, 1'b0, 5'h0,
            legal(5'(m)) ? "R4 live write" : "R3 illegal mode");
    end

    // R8/R9: every code as exception target
    for (int t = 0; t < 32; t++) begin
      apply(1'b0, 1'b0, 32'h0, 1'b1, 5'b10011, "R8 enter svc");
      apply(1'b1, 1'b0, {4'(t), 20'h0, 8'b0001_0011}, 1'b0, 5'h0, "R4 live write");
      apply(1'b0, 1'b0, 32'h0, 1'b1, 5'(t),
            (bank_of(5'(t)) >= 0) ? "R8 exception" : "R9 bad exception");
    end

    // R6: per-bank saved words, aliases share a bank
    foreach (codes[k]) begin
      apply(1'b1, 1'b0, {4'(k), 20'h0, 3'b110, codes[k]}, 1'b0, 5'h0, "R4 switch");
      apply(1'b1, 1'b1, {4'(k + 3), 20'h5A5A5, 2'(k), 1'b1, codes[(k + 3) % 8]},
            1'b0, 5'h0, "R6 saved write");
      apply(1'b1, 1'b1, {4'(k), 20'h0, 3'b010, 5'b00111}, 1'b0, 5'h0,
            "R3 saved illegal mode");
    end
    foreach (codes[k])
      apply(1'b1, 1'b0, {4'(k), 20'h0, 3'b000, codes[k]}, 1'b0, 5'h0, "R6 revisit");

    // R5/R7: user mode restrictions
    apply(1'b1, 1'b0, 32'h0000_0010, 1'b0, 5'h0, "R4 to user");
    apply(1'b1, 1'b0, 32'hFFFF_FFDB, 1'b0, 5'h0, "R5 user live write");
    apply(1'b1, 1'b1, 32'hA000_0091, 1'b0, 5'h0, "R7 user saved write");
    apply(1'b1, 1'b0, 32'h5000_00D3, 1'b0, 5'h0, "R5 user mode change");
    apply(1'b0, 1'b0, 32'h0, 1'b1, 5'b10001, "R8 fiq entry");
    foreach (codes[k])
      apply(1'b1, 1'b0, {4'(k), 20'h0, 3'b000, codes[k]}, 1'b0, 5'h0, "R7 banks intact");

    // R10: exception and write in the same cycle
    apply(1'b1, 1'b0, 32'h9000_0010, 1'b1, 5'b10010, "R10 exc vs live write");
    apply(1'b1, 1'b1, 32'h3000_0011, 1'b1, 5'b11011, "R10 exc vs saved write");
    apply(1'b1, 1'b0, 32'h6000_0000, 1'b1, 5'b00111, "R9 bad exc lets write");

    // Mixed pseudo-random run
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] op;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      op = lfsr[2:0];
      case (op)
        3'd0, 3'd1: apply(1'b1, 1'b0, lfsr ^ {lfsr[15:0], lfsr[31:16]}, 1'b0, 5'h0, "R4 random live");
        3'd2, 3'd3: apply(1'b1, 1'b1, {lfsr[7:0], lfsr[31:8]}, 1'b0, 5'h0, "R6 random saved");
        3'd4:       apply(1'b1, lfsr[9], lfsr, 1'b1, lfsr[14:10], "R10 random both");
        default:    apply(1'b0, 1'b0, 32'h0, 1'b1, lfsr[14:10], "R8 random exception");
      endcase
    end

    finish_run();
  end
endmodule